// File: doc/BRIEF.md
# SDRAM Idle Power-Down Sequencer

This block runs next to an SDRAM command scheduler and takes care of two low-power duties. First, it watches transfer activity and, once the memory has been idle for a delay chosen by a 2-bit code, it asks the scheduler to put the device into power-down. It brings the device back out when a new transfer or a self-refresh request arrives. Second, it holds the device's low-power configuration: refresh temperature compensation, output drive strength and the power-down exit speed. When software changes any of these after initialization, the block issues an extended mode register load carrying the new values. It waits for a moment the update-timing bit allows before doing so.

Commands leave the block one at a time on a valid/accept handshake. The scheduler grants transfers through `xfer_gnt` and starts self-refresh through `sr_go`. The block withholds both while a power-down exit or a configuration load still has to happen first.

Top module: `sdram_lp_sequencer`

## Requirements
- R1: After reset, `cmd_valid`, `pd_active` and `xfer_gnt` are 0 and `cmd_code` is NOP. The configuration fields reset to 0, except the exit-speed bit, which resets to 1 (1 = slow exit, 0 = fast exit). A post-init write of tcr=0, drive=0, exit=1 therefore schedules no load.
- R2: The write port `cfg_wdata` is laid out as [1:0] idle code, [2] exit speed, [3] update timing, [5:4] drive strength, [7:6] temperature compensation. With idle code 00, 01 or 10, a PD_ENTER command appears on the (L+1)-th rising edge that samples `xfer_busy`, `xfer_req` and `sr_req` low, where L is 0, 64 or 128 respectively.
- R3: Idle code 11 never issues PD_ENTER, however long the block stays idle.
- R4: A cycle with `xfer_req` or `xfer_busy` high restarts the idle count from zero.
- R5: Command codes are NOP=0, PD_ENTER=1, PD_EXIT=2, EMRS=3. A command, together with its argument, stays on the outputs until `cmd_accept` is high at a clock edge. A new command is issued only after the previous one has been accepted.
- R6: While the device is in power-down, `xfer_req` causes a PD_EXIT and `xfer_gnt` stays low until that exit has been accepted. When the block is awake with no command outstanding, a request is granted at once.
- R7: Writes made while `init_done` is low update the fields only and never schedule an EMRS.
- R8: After init, a write that changes the temperature compensation, drive strength or exit-speed field schedules one EMRS. Its argument `cmd_arg` is {tcr, drive, exit} (exit in bit 0).
- R9: With update timing 0, a pending EMRS is issued only while `sr_req` is high, and `sr_go` stays low while the load is pending.
- R10: With update timing 1, a pending EMRS is issued only while both `refresh_req` and `pending_access` are high. `sr_req` alone does not issue it.
- R11: A pending EMRS whose trigger is present wins over idle power-down entry. If the device is in power-down, PD_EXIT is issued first and the EMRS follows.
- R12: Several changing writes made before the load is issued produce a single EMRS carrying the latest values.
- R13: A write that leaves all three mode-register fields unchanged schedules no EMRS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data (layout in R2) |
| init_done | input | 1 | Device initialization complete |
| xfer_req | input | 1 | New transfer request from the scheduler |
| xfer_busy | input | 1 | A transfer is in progress |
| refresh_req | input | 1 | Scheduler is issuing a refresh |
| pending_access | input | 1 | A read or write access is waiting |
| sr_req | input | 1 | Self-refresh entry requested |
| cmd_accept | input | 1 | Scheduler takes the current command |
| xfer_gnt | output | 1 | Transfer request may proceed |
| sr_go | output | 1 | Self-refresh entry may proceed |
| pd_active | output | 1 | Device is in power-down |
| cmd_valid | output | 1 | A command is offered |
| cmd_code | output | 2 | Command code (R5) |
| cmd_arg | output | 5 | EMRS argument {tcr, drive, exit} |

## Verification
The hardest situation to reach is a configuration load that becomes due while the device sits in power-down, with the idle timer also expired once the device wakes. That is the case where exit-before-load ordering and load-over-entry priority both decide the outcome. The stimulus gets there in steps. It uses idle code 00 to drop into power-down at once, then writes a changed exit-speed field while asleep. It then raises refresh and pending access together and expects PD_EXIT followed by EMRS instead of another PD_ENTER. Separate directed runs hold the trigger signals in every combination to show that a pending load stays parked until its own trigger appears.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;

    typedef enum logic [1:0] {
        CMD_NOP      = 2'd0,
        CMD_PD_ENTER = 2'd1,
        CMD_PD_EXIT  = 2'd2,
        CMD_EMRS     = 2'd3
    } sdlp_cmd_e;

    localparam logic [1:0] IDLE_NOW   = 2'b00;
    localparam logic [1:0] IDLE_SHORT = 2'b01;
    localparam logic [1:0] IDLE_LONG  = 2'b10;
    localparam logic [1:0] IDLE_NEVER = 2'b11;

endpackage

// File: rtl/sdlp_cfg_regs.sv
module sdlp_cfg_regs #(
    parameter int TCR_W = 2,
    parameter int DS_W  = 2,
    localparam int CFG_W = 4 + DS_W + TCR_W,
    localparam int EMR_W = TCR_W + DS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             init_done,
    input  logic             upd_taken,
    output logic [1:0]       idle_code,
    output logic             upd_sel,
    output logic [EMR_W-1:0] emr_arg,
    output logic             upd_pending
);
    localparam int DS_LO  = 4;
    localparam int TCR_LO = 4 + DS_W;

    typedef struct packed {
        logic [TCR_W-1:0] tcr;
        logic [DS_W-1:0]  ds;
        logic             exit_slow;
        logic             upd_sel;
        logic [1:0]       idle_code;
        logic             pend;
    } cfg_t;

    cfg_t q, d;
    logic [EMR_W-1:0] new_arg;
    logic             changed;

    always_comb begin
        d       = q;
        new_arg = {wr_data[TCR_LO +: TCR_W], wr_data[DS_LO +: DS_W], wr_data[2]};
        changed = wr_en && (new_arg != {q.tcr, q.ds, q.exit_slow});
        if (wr_en) begin
            d.idle_code = wr_data[1:0];
            d.exit_slow = wr_data[2];
            d.upd_sel   = wr_data[3];
            d.ds        = wr_data[DS_LO +: DS_W];
            d.tcr       = wr_data[TCR_LO +: TCR_W];
        end
        d.pend = (q.pend && !upd_taken) || (changed && init_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.exit_slow <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign idle_code   = q.idle_code;
    assign upd_sel     = q.upd_sel;
    assign emr_arg     = {q.tcr, q.ds, q.exit_slow};
    assign upd_pending = q.pend;

    AST_PREINIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !upd_pending) |=> !upd_pending); // R7
    AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_taken && !wr_en) |=> !upd_pending); // R12
endmodule

// File: rtl/sdlp_idle_timer.sv
module sdlp_idle_timer
    import sdlp_pkg::*;
#(
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128,
    localparam int CNT_W = $clog2(LONG_IDLE + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       hold,
    input  logic [1:0] code,
    output logic       expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic [CNT_W-1:0] limit;

    always_comb begin
        case (code)
            IDLE_SHORT: limit = CNT_W'(SHORT_IDLE);
            IDLE_LONG:  limit = CNT_W'(LONG_IDLE);
            default:    limit = '0;
        endcase
        expired = !clear && (code != IDLE_NEVER) && (q.cnt >= limit);
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (!hold && q.cnt < CNT_W'(LONG_IDLE)) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(LONG_IDLE)); // R2
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired || code == IDLE_NOW); // R4
endmodule

// File: rtl/sdlp_cmd_ctrl.sv
module sdlp_cmd_ctrl
    import sdlp_pkg::*;
#(
    parameter int EMR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_req,
    input  logic             sr_req,
    input  logic             refresh_req,
    input  logic             pending_access,
    input  logic             upd_pending,
    input  logic             upd_sel,
    input  logic             expired,
    input  logic [EMR_W-1:0] emr_arg,
    input  logic             cmd_accept,
    output logic             cmd_valid,
    output sdlp_cmd_e        cmd_code,
    output logic [EMR_W-1:0] cmd_arg,
    output logic             pd_active,
    output logic             upd_taken,
    output logic             upd_fire,
    output logic             xfer_gnt,
    output logic             sr_go
);
    typedef struct packed {
        logic             valid;
        sdlp_cmd_e        code;
        logic [EMR_W-1:0] arg;
        logic             pd;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        upd_fire  = upd_pending && (upd_sel ? (refresh_req && pending_access) : sr_req);
        upd_taken = 1'b0;
        d = q;
        if (q.valid) begin
            if (cmd_accept) begin
                d.valid = 1'b0;
                if (q.code == CMD_PD_ENTER) d.pd = 1'b1;
                if (q.code == CMD_PD_EXIT)  d.pd = 1'b0;
            end
        end else if (q.pd) begin
            if (xfer_req || sr_req || upd_fire) begin
                d.valid = 1'b1;
                d.code  = CMD_PD_EXIT;
            end
        end else if (upd_fire) begin
            d.valid   = 1'b1;
            d.code    = CMD_EMRS;
            d.arg     = emr_arg;
            upd_taken = 1'b1;
        end else if (expired) begin
            d.valid = 1'b1;
            d.code  = CMD_PD_ENTER;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.code <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid = q.valid;
    assign cmd_code  = q.valid ? q.code : CMD_NOP;
    assign cmd_arg   = q.arg;
    assign pd_active = q.pd;
    assign xfer_gnt  = xfer_req && !q.pd && !q.valid && !upd_fire;
    assign sr_go     = sr_req && !q.pd && !q.valid && !(upd_pending && !upd_sel);

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_accept) |=> cmd_valid && $stable(cmd_code) && $stable(cmd_arg)); // R5
    AST_WAKE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && xfer_req && !cmd_valid) |=> cmd_valid && cmd_code == CMD_PD_EXIT); // R6
    AST_EMRS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_EMRS) |-> !pd_active); // R11
    AST_NO_ENTRY_UNDER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && upd_fire) |=> !(cmd_valid && cmd_code == CMD_PD_ENTER)); // R11
    AST_FIRE_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !pd_active && upd_fire) |=> cmd_valid && cmd_code == CMD_EMRS); // R8
endmodule

// File: rtl/sdram_lp_sequencer.sv
module sdram_lp_sequencer
    import sdlp_pkg::*;
#(
    parameter int TCR_W      = 2,
    parameter int DS_W       = 2,
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128,
    localparam int CFG_W = 4 + DS_W + TCR_W,
    localparam int EMR_W = TCR_W + DS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             init_done,
    input  logic             xfer_req,
    input  logic             xfer_busy,
    input  logic             refresh_req,
    input  logic             pending_access,
    input  logic             sr_req,
    input  logic             cmd_accept,
    output logic             xfer_gnt,
    output logic             sr_go,
    output logic             pd_active,
    output logic             cmd_valid,
    output logic [1:0]       cmd_code,
    output logic [EMR_W-1:0] cmd_arg
);
    logic [1:0]       idle_code;
    logic             upd_sel;
    logic [EMR_W-1:0] emr_arg;
    logic             upd_pending;
    logic             upd_taken;
    logic             upd_fire;
    logic             expired;
    logic             tmr_clear;
    sdlp_cmd_e        code_e;

    sdlp_cfg_regs #(.TCR_W(TCR_W), .DS_W(DS_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_data     (cfg_wdata),
        .init_done   (init_done),
        .upd_taken   (upd_taken),
        .idle_code   (idle_code),
        .upd_sel     (upd_sel),
        .emr_arg     (emr_arg),
        .upd_pending (upd_pending)
    );

    assign tmr_clear = xfer_req || xfer_busy || sr_req || pd_active;

    sdlp_idle_timer #(.SHORT_IDLE(SHORT_IDLE), .LONG_IDLE(LONG_IDLE)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .hold    (cmd_valid),
        .code    (idle_code),
        .expired (expired)
    );

    sdlp_cmd_ctrl #(.EMR_W(EMR_W)) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .xfer_req       (xfer_req),
        .sr_req         (sr_req),
        .refresh_req    (refresh_req),
        .pending_access (pending_access),
        .upd_pending    (upd_pending),
        .upd_sel        (upd_sel),
        .expired        (expired),
        .emr_arg        (emr_arg),
        .cmd_accept     (cmd_accept),
        .cmd_valid      (cmd_valid),
        .cmd_code       (code_e),
        .cmd_arg        (cmd_arg),
        .pd_active      (pd_active),
        .upd_taken      (upd_taken),
        .upd_fire       (upd_fire),
        .xfer_gnt       (xfer_gnt),
        .sr_go          (sr_go)
    );

    assign cmd_code = code_e;

    AST_RESERVED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_code == IDLE_NEVER && !cmd_valid) |=> !(cmd_valid && cmd_code == CMD_PD_ENTER)); // R3
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_accept) |=> !cmd_valid); // R5
endmodule

// File: tb/tb_sdram_lp_sequencer.sv
`timescale 1ns/1ps
module tb_sdram_lp_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       init_done = 1'b0;
    logic       xfer_req = 1'b0;
    logic       xfer_busy = 1'b1;
    logic       refresh_req = 1'b0;
    logic       pending_access = 1'b0;
    logic       sr_req = 1'b0;
    logic       cmd_accept = 1'b0;
    logic       xfer_gnt, sr_go, pd_active, cmd_valid;
    logic [1:0] cmd_code;
    logic [4:0] cmd_arg;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_lp_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .init_done(init_done), .xfer_req(xfer_req), .xfer_busy(xfer_busy),
        .refresh_req(refresh_req), .pending_access(pending_access), .sr_req(sr_req),
        .cmd_accept(cmd_accept), .xfer_gnt(xfer_gnt), .sr_go(sr_go),
        .pd_active(pd_active), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] mk_cfg(input int tcr, input int ds, input bit upd,
                                          input bit ex, input int idle);
        return {tcr[1:0], ds[1:0], upd, ex, idle[1:0]};
    endfunction

    task automatic wr(input logic [7:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; xfer_busy = 1'b1; xfer_req = 1'b0; sr_req = 1'b0;
        refresh_req = 1'b0; pending_access = 1'b0; cmd_accept = 1'b0;
        cfg_we = 1'b0; init_done = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    localparam int NV = 6;
    localparam int V_CODE [NV] = '{0, 1, 1, 2, 2, 3};
    localparam int V_EDGE [NV] = '{1, 64, 65, 128, 129, 300};
    localparam int V_EXP  [NV] = '{1, 0, 1, 0, 1, 0};

    initial begin
        @(negedge clk);
        // R2 / R3: idle-timeout table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(mk_cfg(0, 0, 0, 1, V_CODE[i]));
            xfer_busy = 1'b0;
            tick(V_EDGE[i]);
            chk(V_CODE[i] == 3 ? "R3 reserved code valid" : "R2 idle entry valid",
                int'(cmd_valid), V_EXP[i]);
            if (V_EXP[i] == 1) chk("R2 entry code", int'(cmd_code), 1);
        end

        // R1: reset state
        do_reset();
        chk("R1 cmd_valid", int'(cmd_valid), 0);
        chk("R1 pd_active", int'(pd_active), 0);
        chk("R1 cmd_code", int'(cmd_code), 0);
        chk("R1 xfer_gnt", int'(xfer_gnt), 0);
        init_done = 1'b1; sr_req = 1'b1;
        wr(mk_cfg(0, 0, 0, 1, 3));
        tick(5);
        chk("R1 exit bit resets to 1, no EMRS", int'(cmd_valid), 0);
        chk("R1 sr_go", int'(sr_go), 1);

        // R4 restart, then R5 hold and R6 exit
        do_reset();
        wr(mk_cfg(0, 0, 0, 1, 1));
        xfer_busy = 1'b0;
        tick(40);
        xfer_req = 1'b1;
        #1 chk("R6 grant when awake", int'(xfer_gnt), 1);
        tick(1);
        xfer_req = 1'b0;
        tick(64);
        chk("R4 restarted count not yet", int'(cmd_valid), 0);
        tick(1);
        chk("R4 entry after restart", int'(cmd_valid), 1);
        tick(5);
        chk("R5 held valid", int'(cmd_valid), 1);
        chk("R5 held code", int'(cmd_code), 1);
        cmd_accept = 1'b1; tick(1); cmd_accept = 1'b0;
        chk("R5 accepted", int'(cmd_valid), 0);
        chk("R6 in power-down", int'(pd_active), 1);
        xfer_req = 1'b1;
        #1 chk("R6 no grant asleep", int'(xfer_gnt), 0);
        tick(1);
        chk("R6 exit code", int'(cmd_code), 2);
        tick(3);
        chk("R6 exit held", int'(cmd_code), 2);
        chk("R6 no grant pending exit", int'(xfer_gnt), 0);
        cmd_accept = 1'b1; tick(1); cmd_accept = 1'b0;
        chk("R6 awake", int'(pd_active), 0);
        chk("R6 grant after exit", int'(xfer_gnt), 1);
        xfer_req = 1'b0; xfer_busy = 1'b1;

        // R7 pre-init writes
        do_reset();
        wr(mk_cfg(2, 1, 0, 0, 3));
        init_done = 1'b1; sr_req = 1'b1;
        tick(5);
        chk("R7 no EMRS from pre-init write", int'(cmd_valid), 0);

        // R9 / R12 / R8 / R13
        sr_req = 1'b0;
        wr(mk_cfg(1, 0, 0, 1, 3));
        wr(mk_cfg(3, 2, 0, 1, 3));
        tick(10);
        chk("R9 parked without sr_req", int'(cmd_valid), 0);
        sr_req = 1'b1;
        #1 chk("R9 sr_go held off", int'(sr_go), 0);
        tick(1);
        chk("R8 EMRS code", int'(cmd_code), 3);
        chk("R12 merged arg", int'(cmd_arg), 29);
        cmd_accept = 1'b1; tick(1); cmd_accept = 1'b0;
        tick(5);
        chk("R12 single EMRS", int'(cmd_valid), 0);
        chk("R9 sr_go after load", int'(sr_go), 1);
        wr(mk_cfg(3, 2, 0, 1, 3));
        tick(5);
        chk("R13 same values no EMRS", int'(cmd_valid), 0);

        // R10
        sr_req = 1'b0;
        wr(mk_cfg(3, 2, 1, 1, 3));
        wr(mk_cfg(3, 2, 1, 0, 3));
        sr_req = 1'b1;
        tick(5);
        chk("R10 sr_req alone", int'(cmd_valid), 0);
        refresh_req = 1'b1;
        tick(5);
        chk("R10 refresh without access", int'(cmd_valid), 0);
        pending_access = 1'b1;
        tick(1);
        chk("R10 EMRS code", int'(cmd_code), 3);
        chk("R10 EMRS arg", int'(cmd_arg), 28);
        cmd_accept = 1'b1; tick(1); cmd_accept = 1'b0;
        refresh_req = 1'b0; pending_access = 1'b0; sr_req = 1'b0;

        // R11 exit first, then EMRS over idle entry
        do_reset();
        init_done = 1'b1;
        wr(mk_cfg(0, 0, 1, 1, 0));
        xfer_busy = 1'b0;
        tick(1);
        chk("R11 setup entry", int'(cmd_code), 1);
        cmd_accept = 1'b1; tick(1); cmd_accept = 1'b0;
        wr(mk_cfg(0, 0, 1, 0, 0));
        refresh_req = 1'b1; pending_access = 1'b1;
        tick(1);
        chk("R11 exit first", int'(cmd_code), 2);
        cmd_accept = 1'b1; tick(1); cmd_accept = 1'b0;
        chk("R11 awake", int'(pd_active), 0);
        tick(1);
        chk("R11 EMRS beats entry", int'(cmd_code), 3);
        chk("R11 EMRS arg", int'(cmd_arg), 0);
        cmd_accept = 1'b1; tick(1); cmd_accept = 1'b0;
        refresh_req = 1'b0; pending_access = 1'b0; xfer_busy = 1'b1;
        tick(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule